// File: doc/BRIEF.md
# Predicate Mask Next-Element Finder

This block walks a vector element index through a predicate mask. Masked-out elements are skipped without one cycle per zero bit. A start pulse captures a mask word and a vector length `vl_i` (1 to the mask width). Bit positions at or above the vector length are replaced by ones, so the search always stops at the vector length. Each advance request moves the index, in one clock, to the next active element.

Inside, a working copy of the mask is kept already shifted, so that its bit 0 is the first position not yet examined. A cascade of halving test-and-shift stages counts the trailing zeros of that copy. The cascade tests 32, 16, 8, 4 and 2 bits, then a final two-bit stage. That stage also recognises a mask that is entirely zero. The same cascade produces the next working word, which has the counted zeros and the consumed element removed. The following advance can therefore be answered at once.

A sequencer uses the block by pulsing `start_i` once per vector instruction. It then holds `adv_i` high and runs the element operation on `idx_o` whenever `valid_o` is high, until `done_o` rises.

Top module: `pred_step_finder`

## Requirements
- R1: During and right after reset, `done_o`=1, `valid_o`=0, `idx_o`=0 and `skip_o`=0, and advance requests leave all outputs unchanged until the first start.
- R2: One cycle after a start pulse, `idx_o`=0, `skip_o`=0, `valid_o`=0 and `done_o`=0.
- R3: When `done_o` is low, an advance moves `idx_o` one cycle later to the lowest mask position that is set, is below the vector length and is above the previously reported index. Before the first advance after a start there is no previous index, so the search begins at position 0. `valid_o` is then 1.
- R4: Each advance sets `skip_o` to the number of positions jumped over: the new `idx_o` minus the previous index minus one. For the first advance after a start, `skip_o` equals the new `idx_o`.
- R5: When no set position below the vector length remains, an advance gives `idx_o` equal to the vector length, with `valid_o`=0 and `done_o`=1. `valid_o` and `done_o` are never both high.
- R6: With an all-zero mask and a vector length equal to the mask width (64), the first advance gives `idx_o`=64, `skip_o`=64 and `done_o`=1.
- R7: While `done_o` is high and there is no start, advances leave `idx_o`, `skip_o`, `valid_o` and `done_o` unchanged.
- R8: When start and advance are asserted in the same cycle, the start takes effect and the advance is dropped. The outputs then match R2, and the later steps follow the newly loaded mask.
- R9: A cycle with neither start nor advance leaves all outputs unchanged.
- R10: Mask input bits at or above the vector length have no effect on the sequence of reported indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Load a new mask and vector length |
| mask_i | input | MASK_W (64) | Predicate mask; bit i enables element i |
| vl_i | input | clog2(MASK_W)+1 (7) | Vector length, 1 to MASK_W |
| adv_i | input | 1 | Advance to the next active element |
| idx_o | output | clog2(MASK_W)+1 (7) | Index of the element reached by the last advance |
| skip_o | output | clog2(MASK_W)+1 (7) | Inactive positions jumped by the last advance |
| valid_o | output | 1 | `idx_o` names an active element below the vector length |
| done_o | output | 1 | No active element remains |

## Verification
Two functions can meet in one cycle. A start can coincide with an advance, and an advance can coincide with the step that exhausts the mask. For the first case, the bench raises start and advance together in the middle of a walk. It expects the cleared state of R2, and then a complete walk of the new mask with no trace of the old one. For the second case, the bench keeps the advance asserted across the exhausting step and one more cycle. It judges that `idx_o` lands exactly on the vector length and that the extra advance changes nothing.

// File: rtl/psf_pkg.sv
`timescale 1ns/1ps
// psf_pkg: shared constants and helpers for the predicate step finder.
// Assumes the mask width is a power of two, at least 4.
package psf_pkg;
    localparam int unsigned PSF_MASK_W_DEF = 64;

    // Width of an index or count that must reach the mask width itself.
    function automatic int unsigned psf_cnt_w(input int unsigned w);
        return $clog2(w) + 1;
    endfunction
endpackage

// File: rtl/psf_pad_load.sv
`timescale 1ns/1ps
// psf_pad_load: builds the word loaded at start. Mask bits below the
// vector length pass through and every other position becomes 1.
// Assumes 1 <= vl_i <= MASK_W.
module psf_pad_load #(
    parameter int unsigned MASK_W = psf_pkg::PSF_MASK_W_DEF,
    parameter int unsigned CNT_W  = psf_pkg::psf_cnt_w(MASK_W)
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic [CNT_W-1:0]  vl_i,
    output logic [MASK_W-1:0] pad_o
);
    // One selector per bit: keep a real mask bit or force the padding one.
    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        assign pad_o[i] = (CNT_W'(i) < vl_i) ? mask_i[i] : 1'b1;
    end
endmodule

// File: rtl/psf_tz_cascade.sv
`timescale 1ns/1ps
// psf_tz_cascade: counts the trailing zeros of word_i with halving
// test-and-shift stages (MASK_W/2 down to 2 bits), then a two-bit final
// stage. Each shift fills the vacated top bits with ones. next_o is the
// word with the counted zeros and the following set bit removed. all_zero_o
// flags an all-zero input, in which case skip_o is MASK_W.
// Assumes MASK_W is a power of two, at least 4.
module psf_tz_cascade #(
    parameter int unsigned MASK_W = psf_pkg::PSF_MASK_W_DEF,
    parameter int unsigned CNT_W  = psf_pkg::psf_cnt_w(MASK_W)
) (
    input  logic [MASK_W-1:0] word_i,
    output logic [CNT_W-1:0]  skip_o,
    output logic [MASK_W-1:0] next_o,
    output logic              all_zero_o
);
    localparam int unsigned LG = $clog2(MASK_W);

    logic [LG-1:0][MASK_W-1:0] lvl;    // lvl[k] enters the stage of width 2^k
    logic [LG-1:0]             zbit;   // zbit[k] carries skip weight 2^k
    logic                      one_gap;
    logic [MASK_W-1:0]         tail;

    assign lvl[LG-1] = word_i;

    // Halving stages: test the low 2^k bits and shift them away if all zero.
    for (genvar k = LG - 1; k >= 1; k--) begin : g_stage
        localparam int unsigned SH = 1 << k;
        assign zbit[k]   = ~|lvl[k][SH-1:0];
        assign lvl[k-1]  = zbit[k] ? {{SH{1'b1}}, lvl[k][MASK_W-1:SH]} : lvl[k];
    end

    assign tail = lvl[0];

    // Final stage: a single zero below a one, or an entirely zero word.
    always_comb begin
        one_gap    = ~tail[0] & tail[1];
        all_zero_o = ~tail[0] & ~tail[1];
        zbit[0]    = one_gap;
    end

    // Skip count, forced to the full width for an all-zero word.
    always_comb begin
        if (all_zero_o) skip_o = CNT_W'(MASK_W);
        else            skip_o = {1'b0, zbit};
    end

    // Drop the counted zero (if any) plus the consumed set bit.
    always_comb begin
        if (one_gap) next_o = {2'b11, tail[MASK_W-1:2]};
        else         next_o = {1'b1,  tail[MASK_W-1:1]};
    end
endmodule

// File: rtl/pred_step_finder.sv
`timescale 1ns/1ps
// pred_step_finder: steps an element index through a predicate mask one
// active element per advance. Start captures the padded mask and vector
// length. Each advance reports the next active index, or the vector length
// when none is left. Start wins over a coincident advance. Advances after
// done are ignored. Assumes 1 <= vl_i <= MASK_W at start.
module pred_step_finder #(
    parameter int unsigned MASK_W = psf_pkg::PSF_MASK_W_DEF,
    parameter int unsigned CNT_W  = psf_pkg::psf_cnt_w(MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [CNT_W-1:0]  vl_i,
    input  logic              adv_i,
    output logic [CNT_W-1:0]  idx_o,
    output logic [CNT_W-1:0]  skip_o,
    output logic              valid_o,
    output logic              done_o
);
    logic [MASK_W-1:0] work_q;    // remaining mask, bit 0 = base_q position
    logic [CNT_W-1:0]  base_q;    // first position not yet examined
    logic [CNT_W-1:0]  vl_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  skip_q;
    logic              valid_q;
    logic              done_q;

    logic [MASK_W-1:0] pad_w;
    logic [MASK_W-1:0] next_w;
    logic [CNT_W-1:0]  skip_w;
    logic              all_zero_w;
    logic [CNT_W:0]    target_w;

    psf_pad_load #(.MASK_W(MASK_W), .CNT_W(CNT_W)) u_pad (
        .mask_i (mask_i),
        .vl_i   (vl_i),
        .pad_o  (pad_w)
    );

    psf_tz_cascade #(.MASK_W(MASK_W), .CNT_W(CNT_W)) u_tz (
        .word_i     (work_q),
        .skip_o     (skip_w),
        .next_o     (next_w),
        .all_zero_o (all_zero_w)
    );

    // Position reached by this advance.
    assign target_w = {1'b0, base_q} + {1'b0, skip_w};

    // Load on start, otherwise step on an advance while not done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q  <= '1;
            base_q  <= '0;
            vl_q    <= '0;
            idx_q   <= '0;
            skip_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b1;
        end else if (start_i) begin
            work_q  <= pad_w;
            base_q  <= '0;
            vl_q    <= vl_i;
            idx_q   <= '0;
            skip_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (adv_i && !done_q) begin
            idx_q   <= target_w[CNT_W-1:0];
            skip_q  <= skip_w;
            valid_q <= target_w < {1'b0, vl_q};
            done_q  <= target_w >= {1'b0, vl_q};
            if (!all_zero_w) begin
                work_q <= next_w;
                base_q <= target_w[CNT_W-1:0] + 1'b1;
            end
        end
    end

    assign idx_o   = idx_q;
    assign skip_o  = skip_q;
    assign valid_o = valid_q;
    assign done_o  = done_q;
endmodule

// File: rtl/psf_checker.sv
`timescale 1ns/1ps
// psf_checker: temporal properties of pred_step_finder, bound to it below.
// Only observes; drives nothing.
module psf_checker #(
    parameter int unsigned MASK_W = psf_pkg::PSF_MASK_W_DEF,
    parameter int unsigned CNT_W  = psf_pkg::psf_cnt_w(MASK_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             adv_i,
    input logic [CNT_W-1:0] idx_o,
    input logic [CNT_W-1:0] skip_o,
    input logic             valid_o,
    input logic             done_o,
    input logic [CNT_W-1:0] vl_q
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (done_o && !valid_o && idx_o == '0 && skip_o == '0));

    p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (idx_o == '0 && skip_o == '0 && !valid_o && !done_o));

    p_valid_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> idx_o < vl_q);

    p_step_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && adv_i && !start_i) |=>
        ({1'b0, idx_o} == {1'b0, $past(idx_o)} + {1'b0, skip_o} + 1'b1));

    p_excl_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && done_o));

    p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idx_o <= CNT_W'(MASK_W));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(idx_o) && $stable(skip_o)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !adv_i) |=>
        ($stable(idx_o) && $stable(skip_o) && $stable(valid_o) && $stable(done_o)));
endmodule

bind pred_step_finder psf_checker #(.MASK_W(MASK_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .adv_i   (adv_i),
    .idx_o   (idx_o),
    .skip_o  (skip_o),
    .valid_o (valid_o),
    .done_o  (done_o),
    .vl_q    (vl_q)
);

// File: tb/pred_step_finder_tb_top.sv
`timescale 1ns/1ps
// Bench: walks many masks and vector lengths and compares each step with
// a bit-by-bit reference search computed here.
module pred_step_finder_tb_top;
    localparam int MW = 64;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [MW-1:0] mask_i = '0;
    logic [CW-1:0] vl_i = '0;
    logic          adv_i = 1'b0;
    logic [CW-1:0] idx_o;
    logic [CW-1:0] skip_o;
    logic          valid_o;
    logic          done_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    pred_step_finder #(.MASK_W(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .vl_i(vl_i), .adv_i(adv_i), .idx_o(idx_o), .skip_o(skip_o),
        .valid_o(valid_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Reference: first set position in [from, vl), else vl.
    function automatic int ref_next(input logic [MW-1:0] m, input int vl, input int from);
        for (int i = from; i < vl; i++) if (m[i]) return i;
        return vl;
    endfunction

    // Load mask m (with random junk above vl) while also asserting adv
    // when collide is set. Check the cleared state.
    task automatic load(input logic [MW-1:0] m, input int vl, input bit collide, output logic [MW-1:0] used);
        logic [MW-1:0] junk;
        junk = {$urandom, $urandom};
        for (int i = 0; i < MW; i++) used[i] = (i < vl) ? m[i] : junk[i];
        @(negedge clk);
        start_i = 1'b1; adv_i = collide; mask_i = used; vl_i = CW'(vl);
        @(negedge clk);
        start_i = 1'b0; adv_i = 1'b0;
        if (collide) begin
            chk("R8 idx", idx_o, 0);
            chk("R8 flags", {valid_o, done_o}, 0);
        end else begin
            chk("R2 idx", idx_o, 0);
            chk("R2 skip", skip_o, 0);
            chk("R2 flags", {valid_o, done_o}, 0);
        end
    endtask

    // Walk the loaded mask to completion, optionally with idle gaps and a
    // stop after max_steps. Returns when done or when the limit is hit.
    task automatic walk(input logic [MW-1:0] m, input int vl, input bit gaps, input int max_steps);
        int prev = -1;
        int e;
        int steps = 0;
        while (steps < max_steps) begin
            e = ref_next(m, vl, prev + 1);
            adv_i = 1'b1;
            @(negedge clk);
            adv_i = 1'b0;
            steps++;
            chk(e < vl ? "R3 idx" : (vl == MW && prev < 0 && e == MW ? "R6 idx" : "R5 idx"), idx_o, e);
            chk("R4 skip", skip_o, e - prev - 1);
            chk(e < vl ? "R3 valid" : "R5 valid", valid_o, e < vl);
            chk("R5 done", done_o, e >= vl);
            if (e >= vl) begin
                // Extra advance while done: nothing moves.
                adv_i = 1'b1;
                @(negedge clk);
                adv_i = 1'b0;
                chk("R7 idx", idx_o, e);
                chk("R7 skip", skip_o, e - prev - 1);
                chk("R7 done", {valid_o, done_o}, 1);
                return;
            end
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk);
                chk("R9 idx", idx_o, e);
                chk("R9 valid", valid_o, 1);
            end
            prev = e;
        end
    endtask

    initial begin
        logic [MW-1:0] used;
        logic [MW-1:0] m;
        int vl;

        // R1: reset state and ignored advance before any start.
        repeat (3) @(negedge clk);
        chk("R1 done", done_o, 1);
        chk("R1 valid", valid_o, 0);
        chk("R1 idx", idx_o, 0);
        rst_n = 1'b1;
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
        chk("R1 adv ignored idx", idx_o, 0);
        chk("R1 adv ignored flags", {valid_o, done_o}, 1);

        // Corner masks.
        load(64'h1, 1, 1'b0, used);            walk(used, 1, 1'b0, 200);
        load(64'h0, 1, 1'b0, used);            walk(used, 1, 1'b0, 200);
        load('1, MW, 1'b0, used);              walk(used, MW, 1'b1, 200);
        load('0, MW, 1'b0, used);              walk(used, MW, 1'b0, 200);   // R6
        load('0, 10, 1'b0, used);              walk(used, 10, 1'b0, 200);
        load(64'h8000_0000_0000_0000, MW, 1'b0, used); walk(used, MW, 1'b0, 200);
        load(64'h8000_0000_0000_0001, MW, 1'b0, used); walk(used, MW, 1'b1, 200);
        load(64'h5555_5555_5555_5555, 63, 1'b0, used); walk(used, 63, 1'b0, 200);

        // R10: bits above vl are random junk; the walk depends only on bits below vl.
        for (int n = 0; n < 300; n++) begin
            m = {$urandom, $urandom};
            if (n % 3 == 1) m = m & {$urandom, $urandom};
            if (n % 3 == 2) m = m & {$urandom, $urandom} & {$urandom, $urandom};
            vl = 1 + int'($urandom % MW);
            load(m, vl, 1'b0, used);
            walk(used, vl, n[0], 200);
        end

        // R8: start and advance together in the middle of a walk.
        for (int n = 0; n < 20; n++) begin
            load({$urandom, $urandom}, MW, 1'b0, used);
            walk(used, MW, 1'b0, 2);
            m = {$urandom, $urandom} & {$urandom, $urandom};
            vl = 1 + int'($urandom % MW);
            load(m, vl, 1'b1, used);
            walk(used, vl, 1'b0, 200);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule